// File: doc/BRIEF.md
# Dual-Threshold Channel Watchdog

This block watches a stream of conversion results. Each result carries a channel number, and there are up to eight channels by default. On every cycle where the valid strobe is high, the block picks one data word. It takes either the main conversion output or the output of a separate fast watchdog filter. It compares that word, as a signed value, against a shared upper limit and a shared lower limit.

A result above the upper limit raises that channel's bit in the high-event vector. A result below the lower limit raises its bit in the low-event vector. Only channels enabled in the monitor mask can raise events.

The flags are sticky. Software or an interrupt controller removes them by pulsing the matching bit of a per-channel clear vector, one clear vector for high events and one for low events. A single summary output is high while any of the flags is set.

Top module: `dual_limit_watch`

## Requirements
- R1: After reset, high_flags, low_flags and any_flag are all zero.
- R2: When use_fast is 0, main_data is compared and fast_data is ignored. When use_fast is 1, fast_data is compared and main_data is ignored.
- R3: A valid result whose selected data is strictly greater than thr_high sets bit in_chan of high_flags. The bit is visible after the next rising clock edge.
- R4: A valid result whose selected data is strictly less than thr_low sets bit in_chan of low_flags. The bit is visible after the next rising clock edge.
- R5: Selected data equal to thr_high or equal to thr_low sets no flag.
- R6: While in_valid is 0, no flag is set, whatever the data inputs hold.
- R7: A result on a channel whose bit in chan_mask is 0 sets no flag.
- R8: A set flag stays set until a 1 is applied on its own bit of clr_high or clr_low. That bit then clears after the next edge, and other bits are unaffected.
- R9: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: any_flag is 1 exactly when at least one of the 16 flags (high or low, any channel) is 1.
- R11: Data and limits are 24-bit two's-complement values and are compared as signed numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result strobe; a comparison happens only when it is high |
| in_chan | input | 3 | Channel number of the result |
| main_data | input | 24 | Main conversion output (signed) |
| fast_data | input | 24 | Fast watchdog-filter output (signed) |
| use_fast | input | 1 | 0 compares main_data, 1 compares fast_data |
| thr_high | input | 24 | Upper limit (signed) |
| thr_low | input | 24 | Lower limit (signed) |
| chan_mask | input | 8 | Per-channel monitor enable |
| clr_high | input | 8 | Per-channel write-one-to-clear for high flags |
| clr_low | input | 8 | Per-channel write-one-to-clear for low flags |
| high_flags | output | 8 | Sticky per-channel high-event flags |
| low_flags | output | 8 | Sticky per-channel low-event flags |
| any_flag | output | 1 | OR of all high and low flags |

## Verification
A new crossing and a clear can land on the same flag in one cycle. Separately, a clear of one flag can coincide with a crossing on a different channel.

The bench provokes the first case by presenting a below-limit result on a channel while pulsing that channel's low clear bit in the same cycle. The flag must stay set after the edge. The second case is judged by checking that only the addressed bit drops, while the new event bit rises.

Every step's expected flag vectors come from a bench-side model built from the requirements. The monitor compares them one cycle after the step.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
   // Which data word feeds the limit comparison.
   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_FAST = 1'b1
   } src_e;

   // Outcome of one limit comparison.
   typedef struct packed {
      logic above;
      logic below;
   } cmp_res_t;
endpackage

// File: rtl/dlw_src_sel.sv
module dlw_src_sel #(
   parameter int DATA_W = 24
) (
   input  logic              [DATA_W-1:0] main_data,
   input  logic              [DATA_W-1:0] fast_data,
   input  dlw_pkg::src_e                  src,
   output logic              [DATA_W-1:0] sel_data
);
   import dlw_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("dlw_src_sel: DATA_W must be at least 2");
   end

   always_comb begin
      unique case (src)
         SRC_FAST: sel_data = fast_data;
         default:  sel_data = main_data;
      endcase
   end
endmodule

// File: rtl/dlw_compare.sv
module dlw_compare #(
   parameter int DATA_W = 24,
   parameter int NUM_CH = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] thr_high,
   input  logic [DATA_W-1:0] thr_low,
   input  logic              valid,
   input  logic [CH_W-1:0]   chan,
   input  logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] set_high,
   output logic [NUM_CH-1:0] set_low
);
   import dlw_pkg::*;

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_count
      $error("dlw_compare: NUM_CH must lie in 1..64");
   end

   cmp_res_t res;

   // Strict signed comparisons against both limits.
   always_comb begin
      res.above = $signed(data) > $signed(thr_high);
      res.below = $signed(data) < $signed(thr_low);
   end

   // One-hot channel steering, gated by strobe and monitor mask.
   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic hit;
      assign hit         = valid && mask[g] && (chan == CH_W'(g));
      assign set_high[g] = hit && res.above;
      assign set_low[g]  = hit && res.below;
   end
endmodule

// File: rtl/dlw_flag_bank.sv
module dlw_flag_bank #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_in,
   input  logic [NUM_CH-1:0] clr_in,
   output logic [NUM_CH-1:0] flags
);
   if (NUM_CH < 1) begin : g_bad_count
      $error("dlw_flag_bank: NUM_CH must be positive");
   end

   // Sticky bits: clear first, then set, so a set wins a collision.
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_in) | set_in;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set_in[g] |=> flags[g]);
      assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_in[g] && !set_in[g]) |=> !flags[g]);
      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !clr_in[g]) |=> flags[g]);
      assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags[g] && !set_in[g]) |=> !flags[g]);
   end
endmodule

// File: rtl/dual_limit_watch.sv
module dual_limit_watch #(
   parameter int DATA_W = 24,
   parameter int NUM_CH = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [DATA_W-1:0] main_data,
   input  logic [DATA_W-1:0] fast_data,
   input  logic              use_fast,
   input  logic [DATA_W-1:0] thr_high,
   input  logic [DATA_W-1:0] thr_low,
   input  logic [NUM_CH-1:0] chan_mask,
   input  logic [NUM_CH-1:0] clr_high,
   input  logic [NUM_CH-1:0] clr_low,
   output logic [NUM_CH-1:0] high_flags,
   output logic [NUM_CH-1:0] low_flags,
   output logic              any_flag
);
   import dlw_pkg::*;

   logic [DATA_W-1:0] sel_data;
   logic [NUM_CH-1:0] set_high;
   logic [NUM_CH-1:0] set_low;

   dlw_src_sel #(.DATA_W(DATA_W)) u_sel (
      .main_data (main_data),
      .fast_data (fast_data),
      .src       (use_fast ? SRC_FAST : SRC_MAIN),
      .sel_data  (sel_data)
   );

   dlw_compare #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_cmp (
      .data     (sel_data),
      .thr_high (thr_high),
      .thr_low  (thr_low),
      .valid    (in_valid),
      .chan     (in_chan),
      .mask     (chan_mask),
      .set_high (set_high),
      .set_low  (set_low)
   );

   dlw_flag_bank #(.NUM_CH(NUM_CH)) u_high (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (set_high),
      .clr_in (clr_high),
      .flags  (high_flags)
   );

   dlw_flag_bank #(.NUM_CH(NUM_CH)) u_low (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (set_low),
      .clr_in (clr_low),
      .flags  (low_flags)
   );

   assign any_flag = (|high_flags) | (|low_flags);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // A channel left out of the mask never gains a flag.
      assert_mask_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!chan_mask[g] && !high_flags[g]) |=> !high_flags[g]);
      assert_mask_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!chan_mask[g] && !low_flags[g]) |=> !low_flags[g]);
   end

   assert_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_flag) |-> ($countones({high_flags, low_flags}) > 0));
endmodule

// File: tb/tb_dual_limit_watch.sv
module tb_dual_limit_watch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_chan = '0;
   logic [23:0] main_data = '0;
   logic [23:0] fast_data = '0;
   logic        use_fast = 1'b0;
   logic [23:0] thr_high = '0;
   logic [23:0] thr_low = '0;
   logic [7:0]  chan_mask = '0;
   logic [7:0]  clr_high = '0;
   logic [7:0]  clr_low = '0;
   logic [7:0]  high_flags;
   logic [7:0]  low_flags;
   logic        any_flag;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] hi;
      logic [7:0] lo;
      logic       any;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] m_hi = '0;
   logic [7:0] m_lo = '0;

   always #5 clk = ~clk;

   dual_limit_watch dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .main_data(main_data), .fast_data(fast_data), .use_fast(use_fast),
      .thr_high(thr_high), .thr_low(thr_low), .chan_mask(chan_mask),
      .clr_high(clr_high), .clr_low(clr_low),
      .high_flags(high_flags), .low_flags(low_flags), .any_flag(any_flag)
   );

   // Driver: applies one cycle of stimulus and queues the expected result.
   task automatic step(input bit v, input int ch, input int md, input int fd,
                       input bit fast, input int th, input int tl,
                       input logic [7:0] mask, input logic [7:0] ch_hi,
                       input logic [7:0] ch_lo, input string tag);
      exp_t e;
      int   d;
      bit   sh;
      bit   sl;
      in_valid  = v;
      in_chan   = 3'(ch);
      main_data = 24'(md);
      fast_data = 24'(fd);
      use_fast  = fast;
      thr_high  = 24'(th);
      thr_low   = 24'(tl);
      chan_mask = mask;
      clr_high  = ch_hi;
      clr_low   = ch_lo;
      d  = fast ? fd : md;
      sh = v && mask[ch] && (d > th);
      sl = v && mask[ch] && (d < tl);
      m_hi = (m_hi & ~ch_hi) | (8'(sh) << ch);
      m_lo = (m_lo & ~ch_lo) | (8'(sl) << ch);
      e.hi  = m_hi;
      e.lo  = m_lo;
      e.any = (m_hi != 0) || (m_lo != 0);
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compares the outputs just after each edge.
   always @(posedge clk) begin
      if (rst_n) begin
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (high_flags !== e.hi || low_flags !== e.lo || any_flag !== e.any) begin
               errors++;
               $display("FAIL %s: got hi=%h lo=%h any=%b expected hi=%h lo=%h any=%b",
                        e.tag, high_flags, low_flags, any_flag, e.hi, e.lo, e.any);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (high_flags !== 8'h00 || low_flags !== 8'h00 || any_flag !== 1'b0) begin
         errors++;
         $display("FAIL R1: got hi=%h lo=%h any=%b expected 00 00 0",
                  high_flags, low_flags, any_flag);
      end
      rst_n = 1'b1;
      //    v  ch  main      fast    f  thH   thL   mask   clrH   clrL
      step(0, 2, 9000,     9000,   0, 500, -200, 8'hF7, 8'h00, 8'h00, "R6 no strobe");
      step(1, 2, 1000,     0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R3 above high");
      step(1, 5, -1000,    0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R4 below low");
      step(1, 1, 500,      0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R5 equal high");
      step(1, 1, -200,     0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R5 equal low");
      step(1, 3, 99999,    0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R7 masked channel");
      step(1, 0, 0,        7000,   1, 500, -200, 8'hF7, 8'h00, 8'h00, "R2 fast source");
      step(1, 6, 0,        7000,   0, 500, -200, 8'hF7, 8'h00, 8'h00, "R2 main source");
      step(0, 0, 0,        0,      0, 500, -200, 8'hF7, 8'h00, 8'h00, "R8 sticky");
      step(1, 7, -5000,    0,      0, 500, -200, 8'hF7, 8'h04, 8'h00, "R8 clear one bit");
      step(1, 5, -3000,    0,      0, 500, -200, 8'hF7, 8'h00, 8'h20, "R9 set beats clear");
      step(1, 4, -5,       0,      0, 3,   -200, 8'hF7, 8'h00, 8'h00, "R11 negative vs positive");
      step(1, 4, 8388607,  0,      0, -1,  -9000000, 8'hF7, 8'h00, 8'h00, "R11 max vs minus one");
      step(0, 0, 0,        0,      0, 0,   0,    8'hFF, 8'h11, 8'hA0, "R8 partial clear");
      step(0, 0, 0,        0,      0, 0,   0,    8'hFF, 8'hFF, 8'hFF, "R10 all cleared");
      step(1, 3, -70000,   0,      0, 10,  -10,  8'hFF, 8'h00, 8'h00, "R10 single low flag");
      in_valid = 1'b0;
      clr_high = '0;
      clr_low  = '0;
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule